// File: doc/BRIEF.md
# Programmable Bidirectional I/O Cell Bank

A bank of pad-side cells placed between internal logic and the package pins. Each cell has its own static 6-bit configuration word. The word picks the direction of the pin: input only, always-driving output, or a bidirectional pin with three-state control. It also picks the drive style, push-pull or open-drain, and the source of the output enable.

The enable source is one of two chip-wide output-enable inputs, each with a per-cell polarity bit, or a per-cell enable that the logic array produces. Whatever the configuration, the level on every pad is sampled on each clock and returned to the internal input bus. This lets output and bidirectional cells read back their own pin.

The pad is modelled at the logic level as a three-state net. Slew rate, drive strength and any analog behaviour are outside the model.

Top module: `io_cell_bank`

## Requirements
- R1: A cell whose mode field (bits [1:0] of its word) is 00 (input only) or 11 (reserved) never drives its pad, whatever the enables and data are.
- R2: A cell with mode 01 (output) drives its pad whether or not any enable is asserted.
- R3: A cell with mode 10 (bidirectional) drives its pad only while its selected enable is active, and releases it otherwise.
- R4: With bit [2] = 0 (push-pull), a driving cell puts its data value on the pad, both 0 and 1.
- R5: With bit [2] = 1 (open-drain), a driving cell pulls the pad low when the data is 0 and releases it to high impedance when the data is 1.
- R6: An all-zero configuration word (the erased state) selects push-pull drive, input-only mode and an active-high global enable A.
- R7: Enable-source field bits [4:3] select global enable A (00), global enable B (01) or the cell's logic enable (10).
- R8: Enable-source code 11 keeps a bidirectional cell disabled even when every enable input is high.
- R9: Bit [5] = 1 inverts the chosen global enable (A or B), so that it is active low. The bit has no effect on the logic enable.
- R10: Each bit of din_o shows its pad level as it was at the previous rising clock edge, in every mode. Synchronous reset clears din_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the read-back sampler |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | NUM_CELLS*6 | Configuration words; cell k uses bits [6k+5:6k] |
| goe_a_i | input | 1 | Global output enable A |
| goe_b_i | input | 1 | Global output enable B |
| logic_oe_i | input | NUM_CELLS | Logic-generated enable, one per cell |
| dout_i | input | NUM_CELLS | Output data from the logic, one per cell |
| din_o | output | NUM_CELLS | Sampled pad levels returned to the input bus |
| pad_io | inout | NUM_CELLS | Three-state pads |

## Verification
Assertions check on every cycle that input-only and reserved cells keep their drivers off, and that open-drain cells never drive a 1. They also check that an output-mode push-pull cell always drives, that source code 11 disables a bidirectional cell, and that din_o follows the pad with one cycle of delay. Only the bench scenarios can show the pin levels themselves, because that needs a pull-up and an outside driver on the pad. The same holds for the enable selection and polarity for each combination of inputs, for several cells configured differently at the same time, and for the reset of the read-back path.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;

    typedef enum logic [1:0] {
        MODE_IN    = 2'b00,
        MODE_OUT   = 2'b01,
        MODE_BIDIR = 2'b10,
        MODE_RSV   = 2'b11
    } cell_mode_e;

    typedef enum logic [1:0] {
        EN_GLOBAL_A = 2'b00,
        EN_GLOBAL_B = 2'b01,
        EN_LOGIC    = 2'b10,
        EN_OFF      = 2'b11
    } en_src_e;

    // Field order fixes the bit layout: glb_inv [5], en_src [4:3], open_drain [2], mode [1:0]
    typedef struct packed {
        logic       glb_inv;
        en_src_e    en_src;
        logic       open_drain;
        cell_mode_e mode;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    function automatic logic pick_enable(cell_cfg_t c, logic ga, logic gb, logic lg);
        logic r;
        case (c.en_src)
            EN_GLOBAL_A: r = ga ^ c.glb_inv;
            EN_GLOBAL_B: r = gb ^ c.glb_inv;
            EN_LOGIC:    r = lg;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic mode_drives(cell_mode_e m, logic en);
        logic r;
        case (m)
            MODE_OUT:   r = 1'b1;
            MODE_BIDIR: r = en;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/io_en_select.sv
module io_en_select
    import io_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      goe_a,
    input  logic      goe_b,
    input  logic      logic_oe,
    output logic      en
);
    always_comb begin
        en = pick_enable(cfg, goe_a, goe_b, logic_oe);
    end
endmodule

// File: rtl/io_pad_driver.sv
module io_pad_driver
    import io_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      en,
    input  logic      dout,
    output pad_drv_t  drv
);
    logic active;

    always_comb begin
        active = mode_drives(cfg.mode, en);
        if (cfg.open_drain) begin
            drv.oe  = active & ~dout;
            drv.val = 1'b0;
        end else begin
            drv.oe  = active;
            drv.val = dout;
        end
    end
endmodule

// File: rtl/io_pad_sampler.sv
module io_pad_sampler #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] din_q
);
    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= pad_i;
    end

    // R10
    readback_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> din_q == $past(pad_i));
endmodule

// File: rtl/io_cell_bank.sv
module io_cell_bank
    import io_cell_pkg::*;
#(
    parameter int NUM_CELLS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CELLS*CFG_W-1:0] cfg_i,
    input  logic                       goe_a_i,
    input  logic                       goe_b_i,
    input  logic [NUM_CELLS-1:0]       logic_oe_i,
    input  logic [NUM_CELLS-1:0]       dout_i,
    output logic [NUM_CELLS-1:0]       din_o,
    inout  wire  [NUM_CELLS-1:0]       pad_io
);

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        cell_cfg_t cfg;
        logic      en;
        pad_drv_t  drv;

        assign cfg = cell_cfg_t'(cfg_i[i*CFG_W +: CFG_W]);

        io_en_select u_sel (
            .cfg      (cfg),
            .goe_a    (goe_a_i),
            .goe_b    (goe_b_i),
            .logic_oe (logic_oe_i[i]),
            .en       (en)
        );

        io_pad_driver u_drv (
            .cfg  (cfg),
            .en   (en),
            .dout (dout_i[i]),
            .drv  (drv)
        );

        assign pad_io[i] = drv.oe ? drv.val : 1'bz;

        // R1
        in_never_drives_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg.mode == MODE_IN || cfg.mode == MODE_RSV) |-> !drv.oe);
        // R5
        od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg.open_drain && drv.oe) |-> !drv.val);
        // R2
        out_always_drives_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg.mode == MODE_OUT && !cfg.open_drain) |-> drv.oe);
        // R8
        src_off_disables_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg.mode == MODE_BIDIR && cfg.en_src == EN_OFF) |-> !drv.oe);
    end

    io_pad_sampler #(.WIDTH(NUM_CELLS)) u_smp (
        .clk   (clk),
        .rst   (rst),
        .pad_i (pad_io),
        .din_q (din_o)
    );

endmodule

// File: tb/sim_io_cell_bank.sv
module sim_io_cell_bank;
    localparam int N  = 4;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [N*CW-1:0] cfg;
    logic          goe_a, goe_b;
    logic [N-1:0]  loe, dout, ext_low, din;
    wire  [N-1:0]  pad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    for (genvar k = 0; k < N; k++) begin : g_ext
        pullup (pad[k]);
        assign pad[k] = ext_low[k] ? 1'b0 : 1'bz;
    end

    io_cell_bank #(.NUM_CELLS(N)) u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (cfg),
        .goe_a_i    (goe_a),
        .goe_b_i    (goe_b),
        .logic_oe_i (loe),
        .dout_i     (dout),
        .din_o      (din),
        .pad_io     (pad)
    );

    // {req[15:12], cfg[11:6] = {inv, src[1:0], od, mode[1:0]}, a, b, loe, dout, ext_low, exp_pad}
    localparam int NV = 22;
    localparam logic [15:0] VEC [NV] = '{
        {4'd6,  6'b000000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 erased: input only
        {4'd1,  6'b000000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R1 input reads outside low
        {4'd1,  6'b000011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 reserved mode
        {4'd2,  6'b000001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 output, no enable
        {4'd4,  6'b000001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 push-pull high
        {4'd5,  6'b000101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 open-drain low
        {4'd5,  6'b000101, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 open-drain released
        {4'd3,  6'b000010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 bidir enabled
        {4'd3,  6'b000010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 bidir released
        {4'd3,  6'b000010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 released, outside low
        {4'd7,  6'b001010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 source B inactive
        {4'd7,  6'b001010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 source B active
        {4'd7,  6'b010010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 logic enable active
        {4'd7,  6'b010010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 logic enable inactive
        {4'd8,  6'b011010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R8 source off
        {4'd9,  6'b100010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 A active low, asserted
        {4'd9,  6'b100010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 A active low, idle
        {4'd9,  6'b101010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 B active low, asserted
        {4'd9,  6'b110010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 logic enable unaffected
        {4'd5,  6'b000110, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 bidir open-drain data 1
        {4'd5,  6'b000110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 bidir open-drain data 0
        {4'd4,  6'b000010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}  // R4 bidir push-pull high
    };

    task automatic check(input int req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg = '0; goe_a = 1'b1; goe_b = 1'b1;
        loe = '1; dout = '0; ext_low = '0;
        repeat (3) @(negedge clk);
        // R10 reset state of the read-back bus
        check(10, din[0], 1'b0, "din cleared by reset");
        check(10, din[3], 1'b0, "din cleared by reset");
        rst = 1'b0;
        @(negedge clk);
        // R6 erased words: no cell drives although enables are high and data is 0
        for (int k = 0; k < N; k++) check(6, pad[k], 1'b1, "erased cell pad");

        // table walk on cell 0
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg[CW-1:0] = VEC[v][11:6];
            goe_a       = VEC[v][5];
            goe_b       = VEC[v][4];
            loe[0]      = VEC[v][3];
            dout[0]     = VEC[v][2];
            ext_low[0]  = VEC[v][1];
            #1;
            check(int'(VEC[v][15:12]), pad[0], VEC[v][0], "pad level");
            @(negedge clk);
            // R10 read-back one edge later
            check(10, din[0], VEC[v][0], "read-back");
        end

        // several cells with different words at once (R2, R3, R5, R1)
        @(negedge clk);
        ext_low = '0; goe_a = 1'b0; goe_b = 1'b0;
        cfg  = {6'b000101, 6'b000000, 6'b010010, 6'b000001};
        loe  = 4'b0000;
        dout = 4'b0100;
        ext_low[1] = 1'b1;
        #1;
        check(2, pad[0], 1'b0, "cell0 output low");
        check(3, pad[1], 1'b0, "cell1 bidir released, outside low");
        check(1, pad[2], 1'b1, "cell2 input ignores data");
        check(5, pad[3], 1'b0, "cell3 open-drain low");
        @(negedge clk);
        check(10, din[1], 1'b0, "cell1 read-back");
        check(10, din[2], 1'b1, "cell2 read-back");

        // R10 mid-run reset clears read-back despite a high pad
        rst = 1'b1;
        @(negedge clk);
        check(10, din[2], 1'b0, "din during reset");
        rst = 1'b0;
        @(negedge clk);
        check(10, din[2], 1'b1, "din after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule